// File: doc/BRIEF.md
# Gather-Read Register Bank

This block is a bank of signed data registers. Each register answers to a fixed address, starting at 1. Writes share one select bus. Putting an address on the select bus together with a clear strobe zeroes that register. Putting the same address on the bus together with a load strobe then adds the data word into the register. A clear followed by a load therefore stores a fresh value. A clear strobe with select 0 zeroes every register at once.

Reads gather several values in one cycle. The read request is a vector of channels, and each channel carries its own address. One cycle later, each channel's slot in the response holds the value stored at that channel's address, so many lookups are served together. A channel holding 0 means "no request" and returns 0. An address beyond the last register also returns 0.

Top module: `gather_reg_bank`

## Requirements
- R1: While reset is held, and after it is released with no write since, every register reads 0 and every response channel is 0.
- R2: A clear strobe with a select of k, where k is from 1 to NUM_REGS, zeroes register k on the next edge and leaves every other register unchanged.
- R3: A clear strobe with a select of 0 zeroes all registers on the next edge.
- R4: A load strobe without a clear strobe, with a select of k (1..NUM_REGS), adds the data word to register k in two's complement, modulo 2^DATA_W. After a clear, this stores the signed value itself. A load with no clear before it accumulates.
- R5: When clear and load are strobed in the same cycle, the clear takes effect and the load is ignored.
- R6: A load with a select of 0 or of a value above NUM_REGS changes no register.
- R7: Channel c takes its address from bits [c*ADDR_W +: ADDR_W] of the request. It returns the addressed register's value in bits [c*DATA_W +: DATA_W] of the response, one clock edge after the request is presented. All channels are served in the same cycle, and several may hit the same register.
- R8: A channel whose address is 0 or above NUM_REGS returns 0.
- R9: A read presented in the same cycle as a write to the same register returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_sel | input | ADDR_W | Write select; 0 means all registers (clear only) |
| wr_clear | input | 1 | Clear strobe |
| wr_load | input | 1 | Load (accumulate) strobe |
| wr_data | input | DATA_W | Signed data word added on a load |
| rd_addr | input | NUM_CH*ADDR_W | Per-channel read addresses |
| rd_data | output | NUM_CH*DATA_W | Per-channel registered read values |

## Verification
The assertions assume that the strobes and the select bus are valid on every cycle after reset. They also assume that a load arriving without a clear is meant to accumulate, so they check the sum and not a replacement. The stimulus drives every input at the falling edge and keeps the strobes low between operations. It presents both out-of-range selects and select 0 on purpose, so the properties for ignored loads and for global clears are exercised. The bench sweeps every combination of addresses, including the unused codes, over all three channels of a six-register configuration.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int BANK_DATA_W_DEF = 32;

  // Addresses 1..n are registers, 0 is "none", so n+1 codes are needed.
  function automatic int addr_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bank_cell.sv
module bank_cell #(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CELL_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_sel_i,
  input  logic              wr_clear_i,
  input  logic              wr_load_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_all_i,
  output logic [DATA_W-1:0] val_o
);
  logic              hit;
  logic              val_en;
  logic [DATA_W-1:0] val_d;
  logic [DATA_W-1:0] val_q;

  assign hit = (wr_sel_i == CELL_ADDR);

  always_comb begin
    val_d  = val_q;
    val_en = 1'b0;
    if (clr_all_i || (hit && wr_clear_i)) begin
      val_d  = '0;
      val_en = 1'b1;
    end else if (hit && wr_load_i) begin
      val_d  = val_q + wr_data_i;
      val_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  assign val_o = val_q;

  assert_hit_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr_clear_i) |=> (val_q == '0));

  assert_global_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (val_q == '0));

  assert_load_accumulates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr_load_i && !wr_clear_i && !clr_all_i)
      |=> (val_q == DATA_W'($past(val_q) + $past(wr_data_i))));

  assert_miss_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !clr_all_i) |=> $stable(val_q));
endmodule

// File: rtl/bank_gather.sv
module bank_gather #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic [DATA_W-1:0]          val_o
);
  // Unmatched codes (0 and above NUM_REGS) fall through to zero.
  always_comb begin
    val_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == ADDR_W'(i + 1)) begin
        val_o = regs_i[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/gather_reg_bank.sv
module gather_reg_bank #(
  parameter  int NUM_REGS = 8,
  parameter  int NUM_CH   = 4,
  parameter  int DATA_W   = bank_pkg::BANK_DATA_W_DEF,
  localparam int ADDR_W   = bank_pkg::addr_width(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        wr_sel,
  input  logic                     wr_clear,
  input  logic                     wr_load,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [NUM_CH*ADDR_W-1:0] rd_addr,
  output logic [NUM_CH*DATA_W-1:0] rd_data
);
  logic                       rst_sync_n;
  logic                       clr_all;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  logic [NUM_CH*DATA_W-1:0]   rd_data_d;
  logic [NUM_CH*DATA_W-1:0]   rd_data_q;

  bank_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign clr_all = wr_clear && (wr_sel == '0);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_cell
    localparam logic [ADDR_W-1:0] CELL_ADDR = ADDR_W'(r + 1);
    bank_cell #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CELL_ADDR (CELL_ADDR)
    ) u_cell (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_sel_i   (wr_sel),
      .wr_clear_i (wr_clear),
      .wr_load_i  (wr_load),
      .wr_data_i  (wr_data),
      .clr_all_i  (clr_all),
      .val_o      (regs_flat[r*DATA_W +: DATA_W])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    bank_gather #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W)
    ) u_gather (
      .regs_i (regs_flat),
      .addr_i (rd_addr[c*ADDR_W +: ADDR_W]),
      .val_o  (rd_data_d[c*DATA_W +: DATA_W])
    );

    assert_idle_chan_zero_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ((rd_addr[c*ADDR_W +: ADDR_W] == '0) ||
       (int'(rd_addr[c*ADDR_W +: ADDR_W]) > NUM_REGS))
        |=> (rd_data[c*DATA_W +: DATA_W] == '0));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_data_q <= '0;
    end else begin
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_data = rd_data_q;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (rd_data == '0));
endmodule

// File: tb/test_gather_reg_bank.sv
module test_gather_reg_bank;
  localparam int NR = 6;
  localparam int NC = 3;
  localparam int DW = 16;
  localparam int AW = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [AW-1:0]  wr_sel;
  logic           wr_clear;
  logic           wr_load;
  logic [DW-1:0]  wr_data;
  logic [NC*AW-1:0] rd_addr;
  logic [NC*DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] model [0:7];

  always #2.5 clk = ~clk;

  gather_reg_bank #(.NUM_REGS(NR), .NUM_CH(NC), .DATA_W(DW)) i_gather_reg_bank (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_clear(wr_clear),
    .wr_load(wr_load), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] expect_of(input logic [AW-1:0] a);
    if (a >= 1 && int'(a) <= NR) return model[a];
    return '0;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic wr(input logic [AW-1:0] sel, input logic clr, input logic ld,
                    input logic [DW-1:0] d);
    @(negedge clk);
    wr_sel = sel; wr_clear = clr; wr_load = ld; wr_data = d;
    @(negedge clk);
    wr_clear = 1'b0; wr_load = 1'b0;
    if (clr) begin
      if (sel == 0) begin
        for (int i = 0; i < 8; i++) model[i] = '0;
      end else if (int'(sel) <= NR) begin
        model[sel] = '0;
      end
    end else if (ld && sel >= 1 && int'(sel) <= NR) begin
      model[sel] = model[sel] + d;
    end
  endtask

  task automatic rd3(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                     input logic [AW-1:0] a2, input string req);
    @(negedge clk);
    rd_addr = {a2, a1, a0};
    @(negedge clk);
    check(req, rd_data[0*DW +: DW], expect_of(a0));
    check(req, rd_data[1*DW +: DW], expect_of(a1));
    check(req, rd_data[2*DW +: DW], expect_of(a2));
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 8; a += 3) rd3(AW'(a), AW'(a + 1), AW'(a + 2), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] old;
    for (int i = 0; i < 8; i++) model[i] = '0;
    rst_n = 1'b0; wr_sel = '0; wr_clear = 1'b0; wr_load = 1'b0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", rd_data[DW-1:0], '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    sweep("R1 after reset");

    // R4: clear-then-load stores signed values; example pair
    wr(3, 1, 0, 0); wr(3, 0, 1, 16'd15);
    wr(4, 1, 0, 0); wr(4, 0, 1, -16'sd23);
    rd3(3, 4, 0, "R7 example gather");
    check("R4 example 15", rd_data[DW-1:0], 16'd15);

    // Fill every register with a distinct value
    for (int a = 1; a <= NR; a++) begin
      wr(AW'(a), 1, 0, 0);
      wr(AW'(a), 0, 1, DW'(a * 1111 - 4000));
    end
    // R7/R8: exhaustive gather over all address codes on all channels
    for (int a0 = 0; a0 < 8; a0++)
      for (int a1 = 0; a1 < 8; a1++)
        for (int a2 = 0; a2 < 8; a2++)
          rd3(AW'(a0), AW'(a1), AW'(a2), "R7 R8 gather sweep");

    // R4: accumulate without clear, including wrap
    wr(2, 0, 1, 16'd500);
    rd3(2, 2, 2, "R4 accumulate");
    wr(5, 1, 0, 0); wr(5, 0, 1, 16'h7fff); wr(5, 0, 1, 16'd1);
    rd3(5, 0, 5, "R4 wrap");
    check("R4 wrap value", rd_data[DW-1:0], 16'h8000);

    // R2: single clear only touches its register
    wr(4, 1, 0, 0);
    sweep("R2 single clear");

    // R5: clear and load together
    wr(3, 1, 1, 16'd99);
    rd3(3, 1, 6, "R5 clear wins");
    check("R5 value", rd_data[DW-1:0], '0);

    // R6: loads with select 0 or out of range
    wr(0, 0, 1, 16'd77);
    wr(7, 0, 1, 16'd77);
    sweep("R6 ignored load");

    // R9: read during write returns old value
    @(negedge clk);
    old = model[2];
    wr_sel = 2; wr_load = 1'b1; wr_data = 16'd5; rd_addr = {3'd0, 3'd0, 3'd2};
    @(negedge clk);
    wr_load = 1'b0;
    check("R9 pre-write value", rd_data[DW-1:0], old);
    model[2] = model[2] + 16'd5;
    rd3(2, 0, 0, "R9 after write");

    // R3: global clear
    wr(0, 1, 0, 0);
    sweep("R3 global clear");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule